// File: doc/BRIEF.md
# Serial Port Data Delay Engine

This block is the bit engine of a frame-synchronised serial port, with one receive path and one transmit path. Both paths run on the bit clock, so one clock cycle is one bit period. A frame-sync pulse starts a word. The word begins after a programmable delay of 0, 1 or 2 bit periods and runs for a programmable length of 8 to 32 bits, MSB first. With a delay of 2, the port can sit on a line where a framing device places one framing bit ahead of each word. The receiver drops that bit. The transmitter leaves the line undriven in that slot, so the framing device or a pull resistor sets its level.

The receiver presents each finished word right-justified and zero-filled, together with a one-cycle valid pulse. The transmitter drives the data line only while it sends a word bit, and releases it at all other times. A frame sync that arrives while a word is still in progress is ignored and reported on an error pulse. The one exception is a frame sync that lands on the final bit edge of a word with a non-zero delay: this is back-to-back framing and starts the next word.

Top module: `sdp_delay_port`

## Requirements
- R1: Delay and word length are captured at the clock edge that accepts a frame sync, and they hold for that whole word. Delay code 3 behaves as delay 2. Length codes 0, 1, 2, 3 and 4 give 8, 12, 16, 20 and 24 bits; codes 5 to 7 give 32 bits.
- R2: With delay 0, the first data bit is sampled at the same edge that sees the frame sync. Bit k is sampled at edge t+k, where t is the frame-sync edge.
- R3: With delay 1, bit k is sampled at edge t+1+k.
- R4: With delay 2, the bit at edge t+1 is a framing bit and never reaches the received word. Bit k is sampled at edge t+2+k.
- R5: Received bits are shifted in MSB first. The word appears on `rx_word_o` right-justified with zeros above, and the value holds until the next word completes.
- R6: `rx_valid_o` is high for exactly the one cycle after the edge that samples the last bit of a word.
- R7: The transmitter sends the low L bits of `tx_word_i`, as captured at the accepted frame sync, MSB first. Bit k is driven with `tx_oe_o` high in the cycle after edge t+d+k. During the d delay cycles, `tx_oe_o` is low.
- R8: After the last bit, `tx_oe_o` stays low until the next word's first bit. `tx_d_o` is 0 whenever `tx_oe_o` is low.
- R9: A frame sync seen while a word is in progress, on any edge other than its last bit edge, is ignored. The word continues unchanged, and the path's error output pulses high for one cycle after that edge.
- R10: A frame sync on the last bit edge of a word is accepted as a new frame when the new delay is 1 or 2, and the finished word still completes. When the new delay is 0, it is treated as R9.
- R11: While `rst_ni` is low, all outputs are 0 and `tx_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_d_i | input | 1 | Receive serial data |
| rx_dly_i | input | 2 | Receive data delay code |
| rx_wlen_i | input | 3 | Receive word length code |
| rx_word_o | output | WORD_W | Last received word, right-justified |
| rx_valid_o | output | 1 | One-cycle word-complete strobe |
| rx_fs_err_o | output | 1 | Unexpected receive frame sync |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_dly_i | input | 2 | Transmit data delay code |
| tx_wlen_i | input | 3 | Transmit word length code |
| tx_word_i | input | WORD_W | Word to send, captured at frame sync |
| tx_d_o | output | 1 | Transmit serial data |
| tx_oe_o | output | 1 | Transmit drive enable; low means high impedance |
| tx_fs_err_o | output | 1 | Unexpected transmit frame sync |

## Verification
Isolated frames are sent for every pair of delay code and length code. Random data on the line makes the framing slot differ from the data bits, so a receiver that keeps the framing bit, or that shifts the word by one place, gives a different word. Frame syncs repeated exactly on the last bit edge separate the back-to-back acceptance from the delay-0 rejection. Syncs spaced slightly shorter than a word, and a long stretch of random syncs and configurations, separate an ignored mid-word sync from one that restarts the word, and show whether the transmit enable drops at the right cycle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int MAX_W = 32;

  function automatic int wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [1:0] dly_eff(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/sdp_frame_seq.sv
module sdp_frame_seq #(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  input  logic [1:0]       dly_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             start_o,
  output logic             new_cap_o,
  output logic             cap_o,
  output logic             last_o,
  output logic             err_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [1:0]       skip_q;
  logic [CNT_W-1:0] left_q;
  logic [1:0]       dly;

  assign dly       = sdp_pkg::dly_eff(dly_i);
  assign cap_o     = busy_q && (skip_q == 2'd0);
  assign last_o    = cap_o && (left_q == CNT_W'(1));
  // a sync on the last bit edge chains the next frame unless it needs that same edge
  assign start_o   = fs_i && (!busy_q || (last_o && (dly != 2'd0)));
  assign err_o     = fs_i && !start_o;
  assign new_cap_o = start_o && (dly == 2'd0);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      skip_q <= 2'd0;
      left_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      skip_q <= (dly == 2'd0) ? 2'd0 : dly - 2'd1;
      left_q <= (dly == 2'd0) ? len_i - CNT_W'(1) : len_i;
    end else if (cap_o) begin
      left_q <= left_q - CNT_W'(1);
      if (last_o) busy_q <= 1'b0;
    end else if (busy_q) begin
      skip_q <= skip_q - 2'd1;
    end
  end

  a_r9_err_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> busy_q);
  a_r4_skip_then_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && skip_q == 2'd1 && !start_o) |=> (busy_q && cap_o));
  a_r1_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/sdp_rx_shift.sv
module sdp_rx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  input  logic              start_i,
  input  logic              new_cap_i,
  input  logic              cap_i,
  input  logic              last_i,
  input  logic              err_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] shifted;

  assign shifted = {acc_q[WORD_W-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= last_i;
      err_o   <= err_i;
      if (last_i) word_o <= shifted;
      // a new frame clears the accumulator; the old word was already taken above
      if (start_i)    acc_q <= new_cap_i ? {{(WORD_W-1){1'b0}}, d_i} : '0;
      else if (cap_i) acc_q <= shifted;
    end
  end

  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r5_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
endmodule

// File: rtl/sdp_tx_shift.sv
module sdp_tx_shift #(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              start_i,
  input  logic              new_cap_i,
  input  logic              cap_i,
  input  logic              busy_i,
  input  logic              err_i,
  output logic              d_o,
  output logic              oe_o,
  output logic              err_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] aligned;

  assign aligned = word_i << (CNT_W'(WORD_W) - len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      d_o   <= 1'b0;
      oe_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      err_o <= err_i;
      if (cap_i) begin
        d_o  <= sh_q[WORD_W-1];
        oe_o <= 1'b1;
        sh_q <= sh_q << 1;
      end else if (new_cap_i) begin
        d_o  <= aligned[WORD_W-1];
        oe_o <= 1'b1;
      end else begin
        d_o  <= 1'b0;
        oe_o <= 1'b0;
      end
      if (start_i) sh_q <= new_cap_i ? aligned << 1 : aligned;
    end
  end

  a_r8_oe_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $past(busy_i || start_i));
  a_r8_d_zero_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !d_o);
endmodule

// File: rtl/sdp_delay_port.sv
module sdp_delay_port #(
  parameter int WORD_W = sdp_pkg::MAX_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_fs_i,
  input  logic              rx_d_i,
  input  logic [1:0]        rx_dly_i,
  input  logic [2:0]        rx_wlen_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              rx_fs_err_o,
  input  logic              tx_fs_i,
  input  logic [1:0]        tx_dly_i,
  input  logic [2:0]        tx_wlen_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_d_o,
  output logic              tx_oe_o,
  output logic              tx_fs_err_o
);
  logic [CNT_W-1:0] rx_len, tx_len;
  logic rx_start, rx_new_cap, rx_cap, rx_last, rx_err, rx_busy;
  logic tx_start, tx_new_cap, tx_cap, tx_last, tx_err, tx_busy;

  assign rx_len = CNT_W'(sdp_pkg::wlen_bits(rx_wlen_i));
  assign tx_len = CNT_W'(sdp_pkg::wlen_bits(tx_wlen_i));

  sdp_frame_seq #(.WORD_W(WORD_W)) u_rx_seq (
    .clk_i, .rst_ni, .fs_i(rx_fs_i), .dly_i(rx_dly_i), .len_i(rx_len),
    .start_o(rx_start), .new_cap_o(rx_new_cap), .cap_o(rx_cap),
    .last_o(rx_last), .err_o(rx_err), .busy_o(rx_busy)
  );

  sdp_rx_shift #(.WORD_W(WORD_W)) u_rx_sh (
    .clk_i, .rst_ni, .d_i(rx_d_i), .start_i(rx_start), .new_cap_i(rx_new_cap),
    .cap_i(rx_cap), .last_i(rx_last), .err_i(rx_err),
    .word_o(rx_word_o), .valid_o(rx_valid_o), .err_o(rx_fs_err_o)
  );

  sdp_frame_seq #(.WORD_W(WORD_W)) u_tx_seq (
    .clk_i, .rst_ni, .fs_i(tx_fs_i), .dly_i(tx_dly_i), .len_i(tx_len),
    .start_o(tx_start), .new_cap_o(tx_new_cap), .cap_o(tx_cap),
    .last_o(tx_last), .err_o(tx_err), .busy_o(tx_busy)
  );

  sdp_tx_shift #(.WORD_W(WORD_W)) u_tx_sh (
    .clk_i, .rst_ni, .word_i(tx_word_i), .len_i(tx_len), .start_i(tx_start),
    .new_cap_i(tx_new_cap), .cap_i(tx_cap), .busy_i(tx_busy), .err_i(tx_err),
    .d_o(tx_d_o), .oe_o(tx_oe_o), .err_o(tx_fs_err_o)
  );

  a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fs_err_o |-> $past(rx_busy));
  a_r6_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rx_busy && !tx_last) || $past(rx_busy));
endmodule

// File: tb/sim_sdp_delay_port.sv
module sim_sdp_delay_port;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_fs_i = 0, rx_d_i = 0, tx_fs_i = 0;
  logic [1:0] dly = 0;
  logic [2:0] wl = 0;
  logic [31:0] tx_word_i = 0, rx_word_o;
  logic rx_valid_o, rx_fs_err_o, tx_d_o, tx_oe_o, tx_fs_err_o;
  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  sdp_delay_port u0 (
    .clk_i(clk), .rst_ni, .rx_fs_i, .rx_d_i, .rx_dly_i(dly), .rx_wlen_i(wl),
    .rx_word_o, .rx_valid_o, .rx_fs_err_o, .tx_fs_i, .tx_dly_i(dly),
    .tx_wlen_i(wl), .tx_word_i, .tx_d_o, .tx_oe_o, .tx_fs_err_o
  );

  // behavioural reference: one frame record, edges counted by integer
  bit m_act = 0;
  int m_c0 = 0, m_len = 0;
  logic [31:0] m_acc = 0, m_txw = 0, e_word = 0;
  logic e_valid = 0, e_err = 0, e_oe = 0, e_d = 0;

  function automatic int len_of(input logic [2:0] c);
    int t [6] = '{8, 12, 16, 20, 24, 32};
    return (c > 3'd5) ? 32 : t[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_act = 0; m_acc = 0; e_word = 0; e_valid = 0; e_err = 0; e_oe = 0; e_d = 0; cyc = 0;
    end else begin
      bit was_act, cap_old, last_old, ok;
      int dn, ln;
      cyc++;
      was_act = m_act;
      cap_old = m_act && cyc >= m_c0 && cyc <= m_c0 + m_len - 1;
      last_old = m_act && cyc == m_c0 + m_len - 1;
      e_valid = 0; e_err = 0; e_oe = 0; e_d = 0;
      if (cap_old) begin
        e_oe = 1; e_d = m_txw[m_len - 1 - (cyc - m_c0)];
        m_acc = {m_acc[30:0], rx_d_i};
        if (last_old) begin e_valid = 1; e_word = m_acc; m_act = 0; end
      end
      if (rx_fs_i) begin
        dn = (dly == 2'd3) ? 2 : int'(dly);
        ln = len_of(wl);
        ok = !was_act || (last_old && dn != 0);
        if (ok) begin
          m_act = 1; m_c0 = cyc + dn; m_len = ln; m_txw = tx_word_i; m_acc = 0;
          if (dn == 0) begin m_acc = {31'd0, rx_d_i}; e_oe = 1; e_d = tx_word_i[ln-1]; end
        end else e_err = 1;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  bit run = 0;
  always @(negedge clk) if (run && rst_ni) begin
    chk(32'(rx_valid_o), 32'(e_valid), "R6 rx_valid");
    chk(rx_word_o, e_word, "R5 rx_word");
    chk(32'(rx_fs_err_o), 32'(e_err), "R9 rx_fs_err");
    chk(32'(tx_fs_err_o), 32'(e_err), "R9 tx_fs_err");
    chk(32'(tx_oe_o), 32'(e_oe), "R7 tx_oe");
    chk(32'(tx_d_o), 32'(e_d), "R8 tx_d");
  end

  task automatic step(input bit fs, input int d, input int w);
    @(negedge clk);
    rx_fs_i = fs; tx_fs_i = fs;
    dly = 2'(d); wl = 3'(w);
    rx_d_i = 1'($urandom_range(0, 1));
    tx_word_i = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({rx_word_o[3:0], rx_valid_o, rx_fs_err_o, tx_d_o, tx_oe_o, tx_fs_err_o}, 0, "R11 reset");
    @(negedge clk); rst_ni = 1; run = 1;
    // R1 R2 R3 R4: isolated frames, every delay code and length code
    for (int d = 0; d < 4; d++)
      for (int w = 0; w < 8; w++) begin
        step(1, d, w);
        for (int i = 0; i < len_of(3'(w)) + 4; i++) step(0, d, w);
      end
    // R10: sync on last bit edge, new delay 1/2 chains, delay 0 rejected
    for (int d = 0; d < 3; d++)
      for (int n = 0; n < 4; n++) begin
        step(1, d == 0 ? 1 : d, 0);
        for (int i = 0; i < (d == 0 ? 1 : d) + 8 - 2; i++) step(0, d, 0);
        step(1, d, 0);
        for (int i = 0; i < 4; i++) step(0, d, 0);
      end
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    // R9: syncs spaced shorter than a word
    for (int n = 0; n < 10; n++) begin
      step(1, n % 3, 1);
      for (int i = 0; i < 5; i++) step(0, n % 3, 1);
    end
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    // random syncs and configurations
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 9) == 0, $urandom_range(0, 3), $urandom_range(0, 7));
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    run = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule